// File: doc/BRIEF.md
# Dual-Port RAM with Reset Sweep Fill

This block is a simple dual-port synchronous memory on one clock, with one write port and one read port. Every input (write enable, write address, write data and read address) is captured in a register on the clock edge. The read data is taken straight from the storage array at the captured read address, with no register after the array. When the read port and the write port hit the same address on the same edge, the read returns the word held before that write. There is no bypass path from write data to read data.

The array has no power-up contents. Instead, a sweep sequencer fills it after reset. While reset is high, the write side of the array is switched over to an internal sequencer. When reset is released, the sequencer writes a fill value to every location, one location per clock, in rising address order. When the last location has been written, `ready` rises and the external write port takes the array back. Software or a neighbouring block waits for `ready` before it writes.

The address and data widths are parameters, both 8 by default. The array holds 2^`AW` words. The fill value is a parameter and defaults to zero.

Top module: `ramsweep_top`

## Requirements
- R1: `wrEn`, `wrAddr`, `wrData` and `rdAddr` are registered on the rising clock edge. `rdData` is driven combinationally from the array at the registered read address, so a read address presented before edge k shows its word on `rdData` from just after edge k. Before edge k, `rdData` still shows the previously captured address.
- R2: If a write and a read to the same address are captured on the same edge, `rdData` shows the old word in the following cycle. If the read address is then held, the new word appears after the next edge.
- R3: While `rst` is high, `ready` is low and external writes have no effect on the array.
- R4: After `rst` falls, the sequencer writes FILL to addresses 0 through 2^AW−1, one per clock edge. `ready` reads high exactly 2^AW edges after the first edge at which `rst` is low. `ready` then stays high until the next reset.
- R5: External writes presented while `ready` is low are ignored, including writes to addresses the sweep has already passed.
- R6: Once `ready` is high, and before any external write, every location reads back as FILL.
- R7: When `rdEn` is low on an edge, the registered read address is kept, and `rdData` keeps showing the word at the last captured address.
- R8: With `ready` high, a write with `wrEn` high stores `wrData` at `wrAddr`. A read captured on any later edge returns that word.
- R9: Asserting `rst` again at any time restarts the sweep, and every location is refilled with FILL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; the fill sweep starts when it falls |
| wrEn | input | 1 | External write enable |
| wrAddr | input | AW | External write address |
| wrData | input | DW | External write data |
| rdEn | input | 1 | Read enable; when low, the registered read address is held |
| rdAddr | input | AW | Read address |
| rdData | output | DW | Word at the registered read address, unregistered after the array |
| ready | output | 1 | High once the fill sweep is complete |

## Verification
The hardest case to bring about is an external write that collides with the sweep: a write to a location the sequencer has already filled, issued while `ready` is still low. The bench holds a write of a non-fill word to address 0 through the whole reset and sweep, and then reads every address back to confirm that only FILL is present. Same-edge read/write collisions are driven on a run of addresses, each one checked for the old word first and the new word on the following cycle. A second reset over a fully patterned array confirms the refill.

// File: rtl/ramsweep_pkg.sv
package ramsweep_pkg;

  // Strobes from the sweep control to the datapath
  typedef struct packed {
    logic useSweep; // write inputs come from the sequencer
    logic sweepWr;  // sequencer writes this cycle
    logic flush;    // clear the input pipeline (reset)
  } sweepCtl_t;

endpackage

// File: rtl/ramsweep_ctrl.sv
module ramsweep_ctrl
  import ramsweep_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output sweepCtl_t     ctl,
  output logic [AW-1:0] sweepAddr,
  output logic          ready
);

  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic          sweeping;
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sweeping <= 1'b1;
      cnt      <= '0;
    end else if (sweeping) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST_ADDR) begin
        sweeping <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.useSweep = sweeping | rst;
    ctl.sweepWr  = sweeping & ~rst;
    ctl.flush    = rst;
  end

  assign sweepAddr = cnt;
  assign ready     = ~sweeping;

endmodule

// File: rtl/ramsweep_dp.sv
module ramsweep_dp
  import ramsweep_pkg::*;
#(
  parameter int            AW   = 8,
  parameter int            DW   = 8,
  parameter logic [DW-1:0] FILL = '0
) (
  input  logic          clk,
  input  sweepCtl_t     ctl,
  input  logic [AW-1:0] sweepAddr,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          muxWrEn;
  logic [AW-1:0] muxWrAddr;
  logic [DW-1:0] muxWrData;

  logic          wrEnQ;
  logic [AW-1:0] wrAddrQ;
  logic [DW-1:0] wrDataQ;
  logic [AW-1:0] rdAddrQ;

  // Write-side multiplexer: sequencer or external port
  always_comb begin
    if (ctl.useSweep) begin
      muxWrEn   = ctl.sweepWr;
      muxWrAddr = sweepAddr;
      muxWrData = FILL;
    end else begin
      muxWrEn   = wrEn;
      muxWrAddr = wrAddr;
      muxWrData = wrData;
    end
  end

  // Input capture registers
  always_ff @(posedge clk) begin
    if (ctl.flush) begin
      wrEnQ   <= 1'b0;
      rdAddrQ <= '0;
    end else begin
      wrEnQ <= muxWrEn;
      if (rdEn) begin
        rdAddrQ <= rdAddr;
      end
    end
    wrAddrQ <= muxWrAddr;
    wrDataQ <= muxWrData;
  end

  // Array write from the captured inputs; the read is unregistered
  always_ff @(posedge clk) begin
    if (wrEnQ) begin
      mem[wrAddrQ] <= wrDataQ;
    end
  end

  assign rdData = mem[rdAddrQ];

endmodule

// File: rtl/ramsweep_top.sv
module ramsweep_top
  import ramsweep_pkg::*;
#(
  parameter int            AW   = 8,
  parameter int            DW   = 8,
  parameter logic [DW-1:0] FILL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic          ready
);

  sweepCtl_t     ctl;
  logic [AW-1:0] sweepAddr;

  ramsweep_ctrl #(.AW(AW)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .sweepAddr(sweepAddr),
    .ready    (ready)
  );

  ramsweep_dp #(.AW(AW), .DW(DW), .FILL(FILL)) dp_i (
    .clk      (clk),
    .ctl      (ctl),
    .sweepAddr(sweepAddr),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );

endmodule

// File: rtl/ramsweep_chk.sv
module ramsweep_chk #(
  parameter int            AW   = 8,
  parameter int            DW   = 8,
  parameter logic [DW-1:0] FILL = '0
) (
  input logic          clk,
  input logic          rst,
  input logic          rdEn,
  input logic          ready,
  input logic [AW-1:0] rdAddrQ,
  input logic          memWrEn,
  input logic [DW-1:0] memWrData
);

  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  logic [AW:0] sweepCnt;
  logic        prevRst;

  always_ff @(posedge clk) begin
    if (rst) begin
      sweepCnt <= '0;
    end else if (!ready) begin
      sweepCnt <= sweepCnt + 1'b1;
    end
  end

  // R3: one edge after reset was seen, ready must be low
  always_ff @(posedge clk) begin
    prevRst <= rst;
    if (prevRst === 1'b1) begin
      a_r3_not_ready_after_reset: assert (!ready);
    end
  end

  // R4: sweep length
  a_r4_sweep_length: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (sweepCnt == DEPTH_W));

  // R4: ready stays high until reset
  a_r4_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R5: while not ready, only fill words reach the array
  a_r5_only_fill_in_sweep: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (!memWrEn || memWrData == FILL));

  // R7: read address held when read enable is low
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdAddrQ));

endmodule

bind ramsweep_top ramsweep_chk #(.AW(AW), .DW(DW), .FILL(FILL)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .rdEn     (rdEn),
  .ready    (ready),
  .rdAddrQ  (dp_i.rdAddrQ),
  .memWrEn  (dp_i.wrEnQ),
  .memWrData(dp_i.wrDataQ)
);

// File: tb/ramsweep_tb.sv
module ramsweep_top_tb_top;

  localparam int            AW    = 8;
  localparam int            DW    = 8;
  localparam int            DEPTH = 1 << AW;
  localparam logic [DW-1:0] FILL  = 8'hA5;

  logic          clk = 1'b0;
  logic          rst;
  logic          wrEn;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic          rdEn;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] rdData;
  logic          ready;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ramsweep_top #(.AW(AW), .DW(DW), .FILL(FILL)) dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .ready(ready)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 29 + 7) ^ 8'h5A);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ready(input string req);
    int got = -1;
    for (int n = 1; n <= DEPTH + 4; n++) begin
      tick();
      if (ready === 1'b1) begin
        got = n;
        break;
      end
    end
    tests++;
    if (got != DEPTH) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, DEPTH);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    // Reset with a hostile external write to address 0 (R3, R5)
    rst = 1'b1; wrEn = 1'b1; wrAddr = '0; wrData = 8'h3C;
    rdEn = 1'b0; rdAddr = '0;
    @(negedge clk);
    tick(); tick(); tick();
    chk("R3 ready low in reset", {7'd0, ready}, 8'd0);

    // Sweep with the write still held (R4, R5)
    rst = 1'b0;
    wait_ready("R4 sweep length");
    wrEn = 1'b0;
    tick();
    chk("R4 ready stays high", {7'd0, ready}, 8'd1);

    // Every location holds FILL (R6); address 0 proves R5 and R3
    for (int a = 0; a < DEPTH; a++) begin
      rdEn = 1'b1; rdAddr = AW'(a);
      tick();
      chk(a == 0 ? "R5 write ignored while not ready" : "R6 fill readback", rdData, FILL);
    end

    // Pattern write then readback (R8)
    rdEn = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      wrEn = 1'b1; wrAddr = AW'(a); wrData = pat(a);
      tick();
    end
    wrEn = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      rdEn = 1'b1; rdAddr = AW'(a);
      tick();
      chk("R8 pattern readback", rdData, pat(a));
    end

    // Read latency (R1): last read was DEPTH-1
    rdEn = 1'b1; rdAddr = AW'(5);
    #1;
    chk("R1 no change before edge", rdData, pat(DEPTH - 1));
    tick();
    chk("R1 word after edge", rdData, pat(5));

    // Read enable low holds the address (R7)
    rdEn = 1'b0; rdAddr = AW'(9);
    tick();
    chk("R7 hold with rdEn low", rdData, pat(5));
    tick();
    chk("R7 hold second cycle", rdData, pat(5));

    // Same-edge collisions (R2)
    for (int a = 16; a < 48; a++) begin
      rdEn = 1'b1; rdAddr = AW'(a);
      wrEn = 1'b1; wrAddr = AW'(a); wrData = ~pat(a);
      tick();
      chk("R2 old data on collision", rdData, pat(a));
      rdEn = 1'b0; wrEn = 1'b0;
      tick();
      chk("R2 new data next cycle", rdData, ~pat(a));
    end

    // Reset again over a patterned array (R9)
    rst = 1'b1;
    tick();
    chk("R3 ready drops on reset", {7'd0, ready}, 8'd0);
    rst = 1'b0;
    wait_ready("R9 resweep length");
    for (int a = 0; a < DEPTH; a++) begin
      rdEn = 1'b1; rdAddr = AW'(a);
      tick();
      chk("R9 refill readback", rdData, FILL);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule